// File: doc/BRIEF.md
# Banked Misaligned Load Unit

This unit serves byte-addressed loads of 1, 2, 4 or 8 bytes from a memory made of four byte-wide banks. The four banks together form one 32-bit row per row address. The unit works out how many rows a request touches and reads them one at a time through a synchronous read port with one cycle of latency. It then shifts the gathered bytes so that the byte at the requested address lands in bits 7:0 of a 64-bit result. A narrow result is zero-extended or sign-extended, chosen per request.

The unit holds one request at a time. A request is taken when `req_valid` and `req_ready` are both high. `req_ready` stays low until the unit pulses `rsp_valid`. When `strict_en` is high and the address is not a multiple of the access size, the unit reports an alignment fault with zero data and issues no memory read.

The controller has five states. ST_IDLE moves to ST_ISSUE when an acceptable request is taken, or to ST_FAULT when strict mode rejects it. ST_ISSUE drives one row read and moves to ST_CAPTURE. ST_CAPTURE stores the returned row. It goes back to ST_ISSUE while rows remain, and otherwise goes to ST_DONE. ST_DONE and ST_FAULT each present the response for one cycle and return to ST_IDLE.

Top module: `banked_load_unit`

## Requirements
- R1: The byte at address A sits in bank A mod 4 (bits 8*(A mod 4)+7 : 8*(A mod 4)) of row A div 4. Results are little-endian: the lowest-addressed byte goes in rsp_data[7:0], the next one in [15:8], and so on. Rows are read in increasing order starting at row A div 4.
- R2: A 4-byte load (req_size=2) at an address that is a multiple of 4 performs exactly one row read.
- R3: A 4-byte load at any other address performs two row reads and returns the four bytes merged in order.
- R4: A 2-byte load (req_size=1) at bank offset 0, 1 or 2 performs one row read. At bank offset 3 it performs two row reads.
- R5: A 1-byte load (req_size=0) from any bank performs one row read and returns that byte in rsp_data[7:0].
- R6: An 8-byte load (req_size=3) at bank offset 0 performs two row reads. At any other bank offset it performs three.
- R7: When req_signed is 1, a 1-, 2- or 4-byte result is sign-extended to 64 bits from its top bit. When req_signed is 0, it is zero-extended.
- R8: When strict_en is 1 and the address is not a multiple of the access size in bytes, the response has rsp_fault=1 and rsp_data=0, and no row read is issued. An aligned access in strict mode, and any access with strict_en=0, completes with rsp_fault=0.
- R9: req_ready is high only while idle. After a request is accepted, exactly one rsp_valid pulse follows. It comes 2*N+1 cycles after acceptance for an access touching N rows, and 1 cycle after acceptance for a fault. req_ready returns high in the cycle after the pulse.
- R10: After reset, req_ready=1, rsp_valid=0 and mem_rd_en=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Load request present |
| req_ready | output | 1 | Unit idle and able to take a request |
| req_addr | input | ADDR_W | Byte address |
| req_size | input | 2 | Access size: 0=1, 1=2, 2=4, 3=8 bytes |
| req_signed | input | 1 | Sign-extend a narrow result |
| strict_en | input | 1 | Fault on accesses not aligned to their size |
| mem_rd_en | output | 1 | Row read strobe |
| mem_rd_row | output | ADDR_W-2 | Row address of the read |
| mem_rd_data | input | 32 | Row data, valid the cycle after mem_rd_en |
| rsp_valid | output | 1 | One-cycle response pulse |
| rsp_data | output | 64 | Right-justified, extended load result |
| rsp_fault | output | 1 | Alignment fault (with rsp_valid) |

## Verification
The assertions assume that `mem_rd_data` is valid exactly one cycle after each `mem_rd_en` and reflects the row on `mem_rd_row`. They also assume that `req_size`, `req_addr`, `req_signed` and `strict_en` are stable while `req_valid` is high. The bench's memory model registers its read data on the clock edge that samples the strobe. The bench raises `req_valid` for a single cycle, only while `req_ready` is high, and holds the other request fields steady for that cycle. Addresses stay below the top of the modelled rows, so a three-row read never wraps.

// File: rtl/bload_pkg.sv
package bload_pkg;

    typedef enum logic [1:0] {
        SZ_B1 = 2'd0,
        SZ_B2 = 2'd1,
        SZ_B4 = 2'd2,
        SZ_B8 = 2'd3
    } acc_size_e;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ISSUE,
        ST_CAPTURE,
        ST_DONE,
        ST_FAULT
    } ld_state_e;

    localparam int ROW_BYTES = 4;
    localparam int ROW_BITS  = 8 * ROW_BYTES;
    localparam int SLOTS     = 4;
    localparam int RES_BITS  = 64;

endpackage

// File: rtl/bload_plan.sv
module bload_plan
    import bload_pkg::*;
(
    input  logic [2:0] addr_lo,
    input  logic [1:0] size,
    output logic [1:0] n_rows,
    output logic       misaligned
);
    logic [3:0] last_byte;

    always_comb begin
        last_byte  = {2'b00, addr_lo[1:0]} + ((4'd1 << size) - 4'd1);
        n_rows     = last_byte[3:2] + 2'd1;
        unique case (acc_size_e'(size))
            SZ_B1:   misaligned = 1'b0;
            SZ_B2:   misaligned = addr_lo[0];
            SZ_B4:   misaligned = |addr_lo[1:0];
            SZ_B8:   misaligned = |addr_lo;
            default: misaligned = 1'b0;
        endcase
    end
endmodule

// File: rtl/bload_merge.sv
module bload_merge
    import bload_pkg::*;
(
    input  logic [SLOTS*ROW_BITS-1:0] rows_flat,
    input  logic [1:0]                offset,
    input  logic [1:0]                size,
    input  logic                      sext,
    output logic [RES_BITS-1:0]       value
);
    logic [SLOTS*ROW_BITS-1:0] shifted;

    always_comb begin
        shifted = rows_flat >> {offset, 3'b000};
        unique case (acc_size_e'(size))
            SZ_B1:   value = {{56{sext & shifted[7]}},  shifted[7:0]};
            SZ_B2:   value = {{48{sext & shifted[15]}}, shifted[15:0]};
            SZ_B4:   value = {{32{sext & shifted[31]}}, shifted[31:0]};
            SZ_B8:   value = shifted[63:0];
            default: value = '0;
        endcase
    end
endmodule

// File: rtl/banked_load_unit.sv
module banked_load_unit
    import bload_pkg::*;
#(
    parameter int ADDR_W = 16
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                req_valid,
    output logic                req_ready,
    input  logic [ADDR_W-1:0]   req_addr,
    input  logic [1:0]          req_size,
    input  logic                req_signed,
    input  logic                strict_en,
    output logic                mem_rd_en,
    output logic [ADDR_W-3:0]   mem_rd_row,
    input  logic [31:0]         mem_rd_data,
    output logic                rsp_valid,
    output logic [63:0]         rsp_data,
    output logic                rsp_fault
);
    localparam int ROW_AW = ADDR_W - 2;

    ld_state_e             state;
    logic [1:0]            cnt;
    logic [1:0]            rd_issued;
    logic [1:0]            nrows_q;
    logic [ADDR_W-1:0]     addr_q;
    logic [1:0]            size_q;
    logic                  sext_q;
    logic [ROW_BITS-1:0]   words [SLOTS];
    logic [SLOTS*ROW_BITS-1:0] words_flat;
    logic [1:0]            plan_rows;
    logic                  plan_mis;
    logic [RES_BITS-1:0]   merged;
    logic                  accept;

    bload_plan u_plan (
        .addr_lo    (req_addr[2:0]),
        .size       (req_size),
        .n_rows     (plan_rows),
        .misaligned (plan_mis)
    );

    for (genvar g = 0; g < SLOTS; g++) begin : g_flat
        assign words_flat[g*ROW_BITS +: ROW_BITS] = words[g];
    end

    bload_merge u_merge (
        .rows_flat (words_flat),
        .offset    (addr_q[1:0]),
        .size      (size_q),
        .sext      (sext_q),
        .value     (merged)
    );

    assign accept = req_valid && req_ready;

    // State register and datapath registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state     <= ST_IDLE;
            cnt       <= '0;
            rd_issued <= '0;
            nrows_q   <= '0;
            addr_q    <= '0;
            size_q    <= '0;
            sext_q    <= 1'b0;
            for (int i = 0; i < SLOTS; i++) words[i] <= '0;
        end else begin
            unique case (state)
                ST_IDLE: begin
                    if (accept) begin
                        addr_q    <= req_addr;
                        size_q    <= req_size;
                        sext_q    <= req_signed;
                        nrows_q   <= plan_rows;
                        cnt       <= '0;
                        rd_issued <= '0;
                        for (int i = 0; i < SLOTS; i++) words[i] <= '0;
                        state     <= (strict_en && plan_mis) ? ST_FAULT : ST_ISSUE;
                    end
                end
                ST_ISSUE: begin
                    rd_issued <= rd_issued + 2'd1;
                    state     <= ST_CAPTURE;
                end
                ST_CAPTURE: begin
                    words[cnt] <= mem_rd_data;
                    if (cnt == nrows_q - 2'd1) begin
                        state <= ST_DONE;
                    end else begin
                        cnt   <= cnt + 2'd1;
                        state <= ST_ISSUE;
                    end
                end
                ST_DONE:  state <= ST_IDLE;
                ST_FAULT: state <= ST_IDLE;
                default:  state <= ST_IDLE;
            endcase
        end
    end

    // Outputs
    always_comb begin
        req_ready  = (state == ST_IDLE);
        mem_rd_en  = (state == ST_ISSUE);
        mem_rd_row = addr_q[ADDR_W-1:2] + ROW_AW'(cnt);
        rsp_valid  = (state == ST_DONE) || (state == ST_FAULT);
        rsp_fault  = (state == ST_FAULT);
        rsp_data   = (state == ST_DONE) ? merged : '0;
    end

    // R10: nothing is requested of memory while the unit advertises idle
    p_idle_no_read_r10: assert property (@(posedge clk) disable iff (!rst_n)
        mem_rd_en |-> !req_ready);

    // R8: a strict-mode rejection never reaches the memory port
    p_fault_no_read_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && strict_en && plan_mis) |=> (!mem_rd_en && rsp_fault));

    // R8: a fault carries no data
    p_fault_zero_r8: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_fault |-> (rsp_valid && rsp_data == '0));

    // R6: number of reads issued matches the rows the access touches
    p_read_count_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && !rsp_fault) |-> (rd_issued == nrows_q));

    // R9: the response pulse is one cycle and the unit is idle right after
    p_rsp_then_ready_r9: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |=> (req_ready && !rsp_valid));

    // R1: successive reads of one request walk up by one row
    p_row_walk_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_CAPTURE && cnt != nrows_q - 2'd1) |=>
            (mem_rd_en && mem_rd_row == $past(mem_rd_row) + ROW_AW'(1)));

endmodule

// File: tb/sim_banked_load_unit.sv
module sim_banked_load_unit;
    localparam int CLK_PERIOD = 10;
    localparam int AW = 8;
    localparam int NROWS = 1 << (AW - 2);

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          req_valid = 1'b0;
    logic          req_ready;
    logic [AW-1:0] req_addr = '0;
    logic [1:0]    req_size = '0;
    logic          req_signed = 1'b0;
    logic          strict_en = 1'b0;
    logic          mem_rd_en;
    logic [AW-3:0] mem_rd_row;
    logic [31:0]   mem_rd_data = '0;
    logic          rsp_valid;
    logic [63:0]   rsp_data;
    logic          rsp_fault;

    int n_tests = 0;
    int n_fail  = 0;
    int rd_count = 0;
    bit finished = 1'b0;

    logic [31:0] mem [NROWS];

    always #(CLK_PERIOD/2) clk = ~clk;

    banked_load_unit #(.ADDR_W(AW)) u0 (
        .clk, .rst_n, .req_valid, .req_ready, .req_addr, .req_size,
        .req_signed, .strict_en, .mem_rd_en, .mem_rd_row, .mem_rd_data,
        .rsp_valid, .rsp_data, .rsp_fault
    );

    function automatic logic [7:0] byte_at(int a);
        return 8'((a * 37 + 11) & 255);
    endfunction

    // memory model: one-cycle synchronous read
    always @(posedge clk) if (mem_rd_en) mem_rd_data <= mem[mem_rd_row];
    always @(negedge clk) if (mem_rd_en) rd_count++;

    task automatic chk(bit ok, string req, logic [63:0] act, logic [63:0] exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [63:0] expect_val(int a, int sz, bit sx);
        logic [63:0] v = '0;
        int nb = 1 << sz;
        for (int i = 0; i < nb; i++) v[8*i +: 8] = byte_at(a + i);
        if (sx && nb < 8 && v[8*nb-1]) for (int i = 8*nb; i < 64; i++) v[i] = 1'b1;
        return v;
    endfunction

    task automatic run_load(int a, int sz, bit sx, bit strict, int exp_reads,
                            bit exp_fault, string req);
        int cyc = 1;
        logic [63:0] exp_d;
        @(negedge clk);
        chk(req_ready === 1'b1, "R9 ready before request", 64'(req_ready), 64'd1);
        rd_count   = 0;
        req_addr   = AW'(a);
        req_size   = 2'(sz);
        req_signed = sx;
        strict_en  = strict;
        req_valid  = 1'b1;
        @(negedge clk);
        req_valid = 1'b0;
        if (!rsp_valid)
            chk(req_ready === 1'b0, "R9 busy drops ready", 64'(req_ready), 64'd0);
        while (!rsp_valid && cyc < 20) begin
            @(negedge clk);
            cyc++;
        end
        exp_d = exp_fault ? 64'd0 : expect_val(a, sz, sx);
        chk(rsp_data === exp_d, req, rsp_data, exp_d);
        chk(rsp_fault === exp_fault, {req, " fault flag"}, 64'(rsp_fault), 64'(exp_fault));
        chk(rd_count == exp_reads, {req, " read count"}, 64'(rd_count), 64'(exp_reads));
        chk(cyc == (exp_fault ? 1 : 2*exp_reads + 1), "R9 latency", 64'(cyc),
            64'(exp_fault ? 1 : 2*exp_reads + 1));
        @(negedge clk);
        chk(rsp_valid === 1'b0 && req_ready === 1'b1, "R9 single pulse then ready",
            64'({rsp_valid, req_ready}), 64'b01);
    endtask

    task automatic t_reset();
        chk(req_ready === 1'b1, "R10 ready at reset", 64'(req_ready), 64'd1);
        chk(rsp_valid === 1'b0, "R10 no rsp at reset", 64'(rsp_valid), 64'd0);
        chk(mem_rd_en === 1'b0, "R10 no read at reset", 64'(mem_rd_en), 64'd0);
    endtask

    task automatic t_bytes();
        for (int k = 0; k < 4; k++) run_load(40 + k, 0, 1'b0, 1'b0, 1, 1'b0, "R5 R1 byte lane");
    endtask

    task automatic t_halves();
        run_load(16, 1, 1'b0, 1'b0, 1, 1'b0, "R4 half off0");
        run_load(17, 1, 1'b0, 1'b0, 1, 1'b0, "R4 half off1");
        run_load(18, 1, 1'b0, 1'b0, 1, 1'b0, "R4 half off2");
        run_load(19, 1, 1'b0, 1'b0, 2, 1'b0, "R4 half off3 crosses");
    endtask

    task automatic t_words();
        run_load(24, 2, 1'b0, 1'b0, 1, 1'b0, "R2 word aligned");
        run_load(25, 2, 1'b0, 1'b0, 2, 1'b0, "R3 word off1");
        run_load(26, 2, 1'b0, 1'b0, 2, 1'b0, "R3 word off2");
        run_load(27, 2, 1'b0, 1'b0, 2, 1'b0, "R3 word off3");
    endtask

    task automatic t_dwords();
        run_load(64, 3, 1'b0, 1'b0, 2, 1'b0, "R6 dword aligned");
        run_load(68, 3, 1'b0, 1'b0, 2, 1'b0, "R6 dword off0 row-aligned");
        run_load(65, 3, 1'b0, 1'b0, 3, 1'b0, "R6 dword off1");
        run_load(71, 3, 1'b0, 1'b0, 3, 1'b0, "R6 dword off3");
    endtask

    task automatic t_signext();
        // byte_at(4)=0x9F has bit 7 set; byte_at(0)=0x0B does not
        run_load(4, 0, 1'b1, 1'b0, 1, 1'b0, "R7 signed byte negative");
        run_load(4, 0, 1'b0, 1'b0, 1, 1'b0, "R7 unsigned byte");
        run_load(0, 0, 1'b1, 1'b0, 1, 1'b0, "R7 signed byte positive");
        run_load(3, 1, 1'b1, 1'b0, 2, 1'b0, "R7 signed half");
        run_load(6, 2, 1'b1, 1'b0, 2, 1'b0, "R7 signed word");
    endtask

    task automatic t_strict();
        run_load(26, 2, 1'b0, 1'b1, 0, 1'b1, "R8 strict word off2");
        run_load(68, 3, 1'b0, 1'b1, 0, 1'b1, "R8 strict dword addr mod8=4");
        run_load(17, 1, 1'b0, 1'b1, 0, 1'b1, "R8 strict half odd");
        run_load(18, 1, 1'b0, 1'b1, 1, 1'b0, "R8 strict half aligned");
        run_load(43, 0, 1'b0, 1'b1, 1, 1'b0, "R8 strict byte");
        run_load(72, 3, 1'b0, 1'b1, 2, 1'b0, "R8 strict dword aligned");
    endtask

    initial begin
        for (int r = 0; r < NROWS; r++)
            for (int k = 0; k < 4; k++) mem[r][8*k +: 8] = byte_at(4*r + k);
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        @(negedge clk);
        t_bytes();
        t_halves();
        t_words();
        t_dwords();
        t_signext();
        t_strict();
        if (!finished) begin
            finished = 1'b1;
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            finished = 1'b1;
            n_tests++;
            n_fail++;
            $display("FAIL watchdog actual=timeout expected=done");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end
endmodule